// File: doc/BRIEF.md
# Direction-Aware Bounds Comparator

This block is the compare unit of an execution stage. It turns one compare operation into a single condition bit that the next branch consumes. The register values and any immediate arrive already resolved at its inputs. The unit registers them on an issue strobe and presents the condition bit one clock later, together with a valid strobe and a three-bit status-flag vector.

There are four operations:

- **Signed range test:** a single-operation `0 <= offset < limit` check.
- **Within-bounds test:** an offset is checked against a lower bound and an upper bound. The lower bound comes from a register or a 5-bit literal.
- **Direction-aware loop-end compare:** the test is "less than" or "greater than", chosen by the sign of a stride register. A slicing loop therefore runs the same way for positive and negative strides.
- **Flag-swap mode:** the greater and less status flags are exchanged under that same sign bit.

A small two-state machine tracks whether the evaluation stage is occupied. The states are `ST_IDLE`, where no operation is in flight, and `ST_EVAL`, where captured operands are being judged.

- Any state goes to `ST_EVAL` when `issue_valid` is high. This covers `ST_IDLE -> ST_EVAL` and `ST_EVAL -> ST_EVAL` for back-to-back issue.
- Any state goes to `ST_IDLE` when `issue_valid` is low.
- While the state is `ST_EVAL`, the output process registers the result and raises `cond_valid`.

Top module: `dir_bounds_cmp`

## Requirements
- R1: An operation issued with `issue_valid` high at clock edge k gives `cond_valid` high for exactly the cycle after edge k+1. Issues on consecutive cycles give results on consecutive cycles. With no issue, `cond_valid` stays low.
- R2: After reset `cond_valid`, `cond_bit` and `cond_flags` are all zero.
- R3: For opcode 0 (range test), `cond_bit` is 1 exactly when `offset[W-1]` is 0 and `offset < opnd_b` compared unsigned.
- R4: For opcode 1 (within-bounds) with `issue_use_imm` = 0, `cond_bit` is 1 exactly when `opnd_b <= offset < opnd_c` compared unsigned.
- R5: For opcode 1 with `issue_use_imm` = 1, the lower bound is `issue_imm` (5 bits) zero-extended, and `opnd_b` is not used.
- R6: For opcodes 0, 2 and 3, `issue_use_imm` and `issue_imm` have no effect on `cond_bit` or `cond_flags`.
- R7: For opcode 2 (direction compare), `cond_bit` is `offset > opnd_b` when `opnd_step[W-1]` is 1 and `offset < opnd_b` otherwise, compared unsigned. Equal operands give 0.
- R8: `cond_flags` is {gt, eq, lt} at bits 2, 1 and 0. It holds the unsigned compare of offset against the second operand, which is the resolved lower bound for opcode 1 and `opnd_b` otherwise. Exactly one flag is set when `cond_valid` is high. For opcodes 0 to 2 the flags are not swapped.
- R9: For opcode 3 (flag swap), the gt and lt flags are exchanged when `opnd_step[W-1]` is 1 and the eq flag is unchanged. `cond_bit` equals the resulting lt flag.
- R10: Operands are captured at the issue edge. Input changes after that edge do not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Operation strobe |
| issue_op | input | 2 | Opcode: 0 range, 1 within, 2 direction compare, 3 flag swap |
| issue_use_imm | input | 1 | Take the lower bound from `issue_imm` (opcode 1 only) |
| issue_imm | input | 5 | Small unsigned literal lower bound |
| opnd_off | input | W | Offset under test, from a register |
| opnd_b | input | W | Limit, lower bound or compare operand |
| opnd_c | input | W | Upper bound (register or fetched value) |
| opnd_step | input | W | Stride register; only its top bit is used |
| cond_valid | output | 1 | Result strobe |
| cond_bit | output | 1 | One-bit condition for the next branch |
| cond_flags | output | 3 | Status flags {gt, eq, lt} |

## Verification
Most of the internal state here is the captured operand set and the one-bit occupancy state. A stale or wrongly loaded capture register shows up as a wrong `cond_bit` or `cond_flags` in the very cycle its result is presented, one clock after issue. A stuck state register shows within one cycle as a missing or extra `cond_valid`. The sign-dependent paths, the literal lower bound and the equality edges are each driven directly, so an inverted direction or an off-by-one bound fails on the first vector that touches it.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [1:0] {
        OP_RANGE    = 2'd0,
        OP_WITHIN   = 2'd1,
        OP_DIRCMP   = 2'd2,
        OP_FLAGSWAP = 2'd3
    } dbc_op_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } dbc_flags_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } dbc_state_e;

endpackage

// File: rtl/dbc_magnitude.sv
module dbc_magnitude
    import dbc_pkg::*;
#(
    parameter int W          = 32,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output dbc_flags_t   flags
);

    logic less;
    logic same;

    assign same = (lhs == rhs);

    generate
        if (SIGNED_CMP) begin : g_signed
            assign less = ($signed(lhs) < $signed(rhs));
        end else begin : g_unsigned
            assign less = (lhs < rhs);
        end
    endgenerate

    always_comb begin
        flags.lt = less;
        flags.eq = same;
        flags.gt = !less && !same;
    end

endmodule

// File: rtl/dbc_operand_sel.sv
module dbc_operand_sel
    import dbc_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5
) (
    input  dbc_op_e          op,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    input  logic [W-1:0]     reg_b,
    output logic [W-1:0]     second
);

    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    assign imm_ext = {{PAD_W{1'b0}}, imm};

    always_comb begin
        if (op == OP_WITHIN && use_imm) begin
            second = imm_ext;
        end else begin
            second = reg_b;
        end
    end

endmodule

// File: rtl/dbc_decide.sv
module dbc_decide
    import dbc_pkg::*;
(
    input  dbc_op_e    op,
    input  dbc_flags_t lo_flags,
    input  dbc_flags_t up_flags,
    input  logic       off_msb,
    input  logic       step_msb,
    output logic       result,
    output dbc_flags_t flags_out
);

    dbc_flags_t swapped;

    always_comb begin
        swapped = lo_flags;
        if (step_msb) begin
            swapped.gt = lo_flags.lt;
            swapped.lt = lo_flags.gt;
        end
    end

    always_comb begin
        result    = 1'b0;
        flags_out = lo_flags;
        unique case (op)
            OP_RANGE:    result = !off_msb && lo_flags.lt;
            OP_WITHIN:   result = !lo_flags.lt && up_flags.lt;
            OP_DIRCMP:   result = step_msb ? lo_flags.gt : lo_flags.lt;
            OP_FLAGSWAP: begin
                flags_out = swapped;
                result    = swapped.lt;
            end
            default:     result = 1'b0;
        endcase
    end

endmodule

// File: rtl/dir_bounds_cmp.sv
module dir_bounds_cmp
    import dbc_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [1:0]       issue_op,
    input  logic             issue_use_imm,
    input  logic [IMM_W-1:0] issue_imm,
    input  logic [W-1:0]     opnd_off,
    input  logic [W-1:0]     opnd_b,
    input  logic [W-1:0]     opnd_c,
    input  logic [W-1:0]     opnd_step,
    output logic             cond_valid,
    output logic             cond_bit,
    output logic [2:0]       cond_flags
);

    localparam int MSB = W - 1;

    dbc_op_e    in_op;
    logic [W-1:0] in_second;

    dbc_state_e state_q;
    dbc_state_e state_d;

    dbc_op_e    cap_op;
    logic [W-1:0] cap_off;
    logic [W-1:0] cap_lower;
    logic [W-1:0] cap_upper;
    logic       cap_sign;

    dbc_flags_t lo_flags;
    dbc_flags_t up_flags;
    dbc_flags_t dec_flags;
    logic       dec_bit;

    assign in_op = dbc_op_e'(issue_op);

    dbc_operand_sel #(.W(W), .IMM_W(IMM_W)) u_sel (
        .op      (in_op),
        .use_imm (issue_use_imm),
        .imm     (issue_imm),
        .reg_b   (opnd_b),
        .second  (in_second)
    );

    // Operand capture at issue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op    <= OP_RANGE;
            cap_off   <= '0;
            cap_lower <= '0;
            cap_upper <= '0;
            cap_sign  <= 1'b0;
        end else if (issue_valid) begin
            cap_op    <= in_op;
            cap_off   <= opnd_off;
            cap_lower <= in_second;
            cap_upper <= opnd_c;
            cap_sign  <= opnd_step[MSB];
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = issue_valid ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = issue_valid ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    dbc_magnitude #(.W(W), .SIGNED_CMP(1'b0)) u_cmp_lo (
        .lhs   (cap_off),
        .rhs   (cap_lower),
        .flags (lo_flags)
    );

    dbc_magnitude #(.W(W), .SIGNED_CMP(1'b0)) u_cmp_up (
        .lhs   (cap_off),
        .rhs   (cap_upper),
        .flags (up_flags)
    );

    dbc_decide u_decide (
        .op        (cap_op),
        .lo_flags  (lo_flags),
        .up_flags  (up_flags),
        .off_msb   (cap_off[MSB]),
        .step_msb  (cap_sign),
        .result    (dec_bit),
        .flags_out (dec_flags)
    );

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_valid <= 1'b0;
            cond_bit   <= 1'b0;
            cond_flags <= '0;
        end else begin
            unique case (state_q)
                ST_EVAL: begin
                    cond_valid <= 1'b1;
                    cond_bit   <= dec_bit;
                    cond_flags <= dec_flags;
                end
                ST_IDLE: cond_valid <= 1'b0;
                default: cond_valid <= 1'b0;
            endcase
        end
    end

    // Assertions
    assert_valid_follows_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> ##1 cond_valid);

    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !cond_valid);

    assert_flags_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cond_valid |-> $onehot(cond_flags));

    assert_range_in_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && cond_bit && $past(cap_op) == OP_RANGE)
            |-> (!$past(cap_off[MSB]) && ($past(cap_off) < $past(cap_lower))));

    assert_dircmp_equal_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && $past(cap_op) == OP_DIRCMP && $past(cap_off) == $past(cap_lower))
            |-> !cond_bit);

    assert_swap_keeps_eq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && $past(cap_op) == OP_FLAGSWAP)
            |-> (cond_flags[1] == ($past(cap_off) == $past(cap_lower))));

    assert_swap_bit_is_lt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_valid && $past(cap_op) == OP_FLAGSWAP) |-> (cond_bit == cond_flags[0]));

endmodule

// File: tb/tb_dir_bounds_cmp.sv
module tb_dir_bounds_cmp;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         issue_valid;
    logic [1:0]   issue_op;
    logic         issue_use_imm;
    logic [4:0]   issue_imm;
    logic [W-1:0] opnd_off;
    logic [W-1:0] opnd_b;
    logic [W-1:0] opnd_c;
    logic [W-1:0] opnd_step;
    logic         cond_valid;
    logic         cond_bit;
    logic [2:0]   cond_flags;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dir_bounds_cmp #(.W(W), .IMM_W(5)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid   (issue_valid),
        .issue_op      (issue_op),
        .issue_use_imm (issue_use_imm),
        .issue_imm     (issue_imm),
        .opnd_off      (opnd_off),
        .opnd_b        (opnd_b),
        .opnd_c        (opnd_c),
        .opnd_step     (opnd_step),
        .cond_valid    (cond_valid),
        .cond_bit      (cond_bit),
        .cond_flags    (cond_flags)
    );

    // Expected {bit, gt, eq, lt} from the requirements
    function automatic logic [3:0] model(input logic [1:0] op, input logic [W-1:0] off,
                                         input logic [W-1:0] b, input logic [W-1:0] c,
                                         input logic [W-1:0] step, input logic ui,
                                         input logic [4:0] imm);
        logic [W-1:0] sec;
        logic gt, eq, lt, r, neg;
        sec = (op == 2'd1 && ui) ? {{(W-5){1'b0}}, imm} : b;
        lt  = off < sec;
        eq  = off == sec;
        gt  = off > sec;
        neg = step[W-1];
        case (op)
            2'd0: r = !off[W-1] && (off < b);
            2'd1: r = (sec <= off) && (off < c);
            2'd2: r = neg ? (off > b) : (off < b);
            default: begin
                if (neg) begin
                    logic t;
                    t = gt; gt = lt; lt = t;
                end
                r = lt;
            end
        endcase
        return {r, gt, eq, lt};
    endfunction

    task automatic check(input string req, input logic got_v, input logic got_b,
                         input logic [2:0] got_f, input logic [3:0] exp);
        checks++;
        if (got_v !== 1'b1 || got_b !== exp[3] || got_f !== exp[2:0]) begin
            failures++;
            $display("FAIL %s: valid=%0b bit=%0b flags=%03b expected valid=1 bit=%0b flags=%03b",
                     req, got_v, got_b, got_f, exp[3], exp[2:0]);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [W-1:0] off, input logic [W-1:0] b,
                         input logic [W-1:0] c, input logic [W-1:0] step, input logic ui,
                         input logic [4:0] imm);
        @(negedge clk);
        issue_valid   = 1'b1;
        issue_op      = op;
        opnd_off      = off;
        opnd_b        = b;
        opnd_c        = c;
        opnd_step     = step;
        issue_use_imm = ui;
        issue_imm     = imm;
    endtask

    task automatic single(input string req, input logic [1:0] op, input logic [W-1:0] off,
                          input logic [W-1:0] b, input logic [W-1:0] c,
                          input logic [W-1:0] step, input logic ui, input logic [4:0] imm);
        drive(op, off, b, c, step, ui, imm);
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        @(posedge clk);
        #1;
        check(req, cond_valid, cond_bit, cond_flags, model(op, off, b, c, step, ui, imm));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        issue_valid = 1'b0; issue_op = 2'd0; issue_use_imm = 1'b0; issue_imm = '0;
        opnd_off = '0; opnd_b = '0; opnd_c = '0; opnd_step = '0;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (cond_valid !== 1'b0 || cond_bit !== 1'b0 || cond_flags !== 3'b000) begin
            failures++;
            $display("FAIL R2: valid=%0b bit=%0b flags=%03b expected 0 0 000",
                     cond_valid, cond_bit, cond_flags);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_range();
        single("R3 inside",       2'd0, 16'd5,      16'd10,     16'd0, 16'd0, 1'b0, 5'd0);
        single("R3 at limit",     2'd0, 16'd10,     16'd10,     16'd0, 16'd0, 1'b0, 5'd0);
        single("R3 last valid",   2'd0, 16'd9,      16'd10,     16'd0, 16'd0, 1'b0, 5'd0);
        single("R3 negative off", 2'd0, 16'h8003,   16'hFFFF,   16'd0, 16'd0, 1'b0, 5'd0);
        single("R3 empty range",  2'd0, 16'd0,      16'd0,      16'd0, 16'd0, 1'b0, 5'd0);
    endtask

    task automatic t_within();
        single("R4 at lower",     2'd1, 16'd4, 16'd4, 16'd8, 16'd0, 1'b0, 5'd0);
        single("R4 below lower",  2'd1, 16'd3, 16'd4, 16'd8, 16'd0, 1'b0, 5'd0);
        single("R4 below upper",  2'd1, 16'd7, 16'd4, 16'd8, 16'd0, 1'b0, 5'd0);
        single("R4 at upper",     2'd1, 16'd8, 16'd4, 16'd8, 16'd0, 1'b0, 5'd0);
    endtask

    task automatic t_imm();
        single("R5 imm at lower",   2'd1, 16'd31, 16'd0,   16'd40, 16'd0, 1'b1, 5'd31);
        single("R5 imm below",      2'd1, 16'd30, 16'd0,   16'd40, 16'd0, 1'b1, 5'd31);
        single("R5 reg b unused",   2'd1, 16'd2,  16'd100, 16'd40, 16'd0, 1'b1, 5'd1);
    endtask

    task automatic t_ignore_imm();
        single("R6 range imm set",  2'd0, 16'd5,  16'd10, 16'd0, 16'd0,     1'b1, 5'd31);
        single("R6 dircmp imm set", 2'd2, 16'd20, 16'd9,  16'd0, 16'd0,     1'b1, 5'd25);
        single("R6 swap imm set",   2'd3, 16'd3,  16'd9,  16'd0, 16'hFFFF, 1'b1, 5'd3);
    endtask

    task automatic t_dircmp();
        single("R7 up below",     2'd2, 16'd3, 16'd9, 16'd0, 16'd2,     1'b0, 5'd0);
        single("R7 up equal",     2'd2, 16'd9, 16'd9, 16'd0, 16'd2,     1'b0, 5'd0);
        single("R7 down above",   2'd2, 16'd9, 16'd3, 16'd0, 16'hFFFE, 1'b0, 5'd0);
        single("R7 down below",   2'd2, 16'd3, 16'd9, 16'd0, 16'hFFFE, 1'b0, 5'd0);
        single("R7 down equal",   2'd2, 16'd5, 16'd5, 16'd0, 16'hFFFE, 1'b0, 5'd0);
    endtask

    task automatic t_flagswap();
        single("R9 neg swap",     2'd3, 16'd3, 16'd9, 16'd0, 16'h8000, 1'b0, 5'd0);
        single("R9 pos no swap",  2'd3, 16'd3, 16'd9, 16'd0, 16'h7FFF, 1'b0, 5'd0);
        single("R9 neg equal",    2'd3, 16'd6, 16'd6, 16'd0, 16'h8000, 1'b0, 5'd0);
        single("R8 raw flags gt", 2'd0, 16'd12, 16'd9, 16'd0, 16'h8000, 1'b0, 5'd0);
    endtask

    task automatic t_backtoback();
        logic [3:0] exp_a;
        logic [3:0] exp_b;
        exp_a = model(2'd2, 16'd1, 16'd2, 16'd0, 16'hFFFF, 1'b0, 5'd0);
        exp_b = model(2'd1, 16'd5, 16'd1, 16'd6, 16'd0,    1'b0, 5'd0);
        drive(2'd2, 16'd1, 16'd2, 16'd0, 16'hFFFF, 1'b0, 5'd0);
        @(posedge clk);
        drive(2'd1, 16'd5, 16'd1, 16'd6, 16'd0, 1'b0, 5'd0);
        @(posedge clk);
        #1;
        check("R1 back-to-back first", cond_valid, cond_bit, cond_flags, exp_a);
        @(negedge clk);
        issue_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R1 back-to-back second", cond_valid, cond_bit, cond_flags, exp_b);
        @(posedge clk);
        #1;
        checks++;
        if (cond_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 single-cycle valid: valid=%0b expected 0", cond_valid);
        end
    endtask

    task automatic t_hold();
        logic [3:0] exp;
        exp = model(2'd0, 16'd4, 16'd8, 16'd0, 16'd0, 1'b0, 5'd0);
        drive(2'd0, 16'd4, 16'd8, 16'd0, 16'd0, 1'b0, 5'd0);
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        issue_op    = 2'd2;
        opnd_off    = 16'd50;
        opnd_b      = 16'd2;
        opnd_step   = 16'hFFFF;
        @(posedge clk);
        #1;
        check("R10 captured operands", cond_valid, cond_bit, cond_flags, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_range();
        t_within();
        t_imm();
        t_ignore_imm();
        t_dircmp();
        t_flagswap();
        t_backtoback();
        t_hold();
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule